// File: doc/BRIEF.md
# GPU Command Packet Assembler

This block takes a stream of 32-bit command words on a valid/ready input and groups them into complete command packets. The top byte of the first word of each packet is an opcode. The opcode fixes how many parameter words follow the header. When the final word of a packet has been taken, the block presents the whole packet of up to twelve words on a wide output. A one-cycle done strobe goes with it, together with the opcode and the total word count, so that a downstream executor can latch the packet in that cycle.

A separate control port carries control commands. Some of them throw away a packet that is only partly collected. One family of them sets a two-bit transfer-direction field. The block does not rasterise or execute the commands. It does not see pixel payloads from image transfers either, because those are routed to another block before they reach this input.

Top module: `gpu_packet_assembler`

## Requirements
- R1: After reset, `pkt_done` is 0, `in_ready` is 1, `dma_dir` is 0, and no packet is in progress. The next accepted word is therefore treated as a header.
- R2: The parameter count is chosen by `in_word[31:24]` of the header. Opcodes 0x20-0x3F are decoded by opcode bits 4:2 (000..111 → 3,6,4,8,5,8,7,11). Opcodes 0x40-0x5F are decoded by bits 4:2 (000..111 → 2,0,3,3,3,0,4,4). Opcodes 0x60-0x67 give 2 when bit 2 is 0 and 3 when it is 1. Opcodes 0x68-0x7F give 1 when bit 2 is 0 and 2 when it is 1. Opcode 0x02 gives 2, 0x80 gives 3, 0xA0 gives 2 and 0xC0 gives 2. Every other opcode gives 0. `pkt_len` is the parameter count plus one.
- R3: A header whose parameter count is 0 raises `pkt_done` in the cycle after it is accepted, with `pkt_len` = 1.
- R4: The header is stored in `pkt_words[31:0]`. Parameter k is stored in `pkt_words[32k+31:32k]`. `pkt_done` rises in the cycle after the last parameter is accepted, and not before.
- R5: `pkt_done` lasts one cycle per packet, and in that cycle it is accompanied by `pkt_opcode` (the header's top byte) and `pkt_len`.
- R6: A control word with `ctrl_word[31:24]` equal to 0x01 or 0x02 drops any partial packet. The next accepted data word is then a header.
- R7: The control word 0x04000000 drops any partial packet and sets `dma_dir` to 0. Any other control word with top byte 0x04 sets `dma_dir` to `ctrl_word[1:0]` and leaves a partial packet intact.
- R8: `in_ready` is 0 in every cycle in which `ctrl_valid` is 1.
- R9: In a cycle where `pkt_done` is 1 and `out_ready` is 0, `in_ready` is 0. When `out_ready` is 1, `in_ready` stays 1.
- R10: A data word offered while `in_ready` is 0 is not taken and has no effect on collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data word offered |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Data word will be taken this cycle if offered |
| ctrl_valid | input | 1 | Control word present |
| ctrl_word | input | 32 | Control command |
| out_ready | input | 1 | Downstream can take a packet |
| pkt_done | output | 1 | Packet complete strobe |
| pkt_opcode | output | 8 | Opcode of the completed packet |
| pkt_len | output | 4 | Total words in the completed packet |
| pkt_words | output | 384 | Packet words, word k at bits 32k+31:32k |
| dma_dir | output | 2 | Transfer-direction field |

## Verification
Packet results are registered. `pkt_done`, `pkt_opcode`, `pkt_len` and the stored words therefore become valid one clock after the edge that accepts the header of a zero-length packet or the last parameter of a longer one. The bench drives every input on the falling edge and reads the results just after the following rising edge. `in_ready` is combinational from `ctrl_valid`, `pkt_done` and `out_ready`, so it is checked in the same cycle as the stimulus, before the next edge. `dma_dir` and the effect of an abort become visible after the edge that samples the control word; the bench observes an abort through which packet completes next.

// File: rtl/gpa_pkg.sv
package gpa_pkg;

    localparam int WORD_W    = 32;
    localparam int MAX_WORDS = 12;
    localparam int OP_W      = 8;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);
    localparam int DIR_W     = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OP_W-1:0]   opcode_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        CTL_NONE,
        CTL_ABORT,
        CTL_DIR,
        CTL_DIR_ABORT
    } ctl_kind_e;

    typedef struct packed {
        opcode_t opcode;
        cnt_t    total;
    } pkt_info_t;

    // Parameter words that follow a header with the given opcode.
    function automatic cnt_t extra_words(input opcode_t op);
        cnt_t n;
        n = '0;
        case (op[7:5])
            3'b001: begin
                case (op[4:2])
                    3'd0: n = cnt_t'(3);
                    3'd1: n = cnt_t'(6);
                    3'd2: n = cnt_t'(4);
                    3'd3: n = cnt_t'(8);
                    3'd4: n = cnt_t'(5);
                    3'd5: n = cnt_t'(8);
                    3'd6: n = cnt_t'(7);
                    default: n = cnt_t'(11);
                endcase
            end
            3'b010: begin
                case (op[4:2])
                    3'd0: n = cnt_t'(2);
                    3'd1: n = cnt_t'(0);
                    3'd2: n = cnt_t'(3);
                    3'd3: n = cnt_t'(3);
                    3'd4: n = cnt_t'(3);
                    3'd5: n = cnt_t'(0);
                    default: n = cnt_t'(4);
                endcase
            end
            3'b011: begin
                if (op[4:3] == 2'b00) n = op[2] ? cnt_t'(3) : cnt_t'(2);
                else                  n = op[2] ? cnt_t'(2) : cnt_t'(1);
            end
            default: begin
                case (op)
                    8'h02:   n = cnt_t'(2);
                    8'h80:   n = cnt_t'(3);
                    8'hA0:   n = cnt_t'(2);
                    8'hC0:   n = cnt_t'(2);
                    default: n = '0;
                endcase
            end
        endcase
        return n;
    endfunction

    function automatic ctl_kind_e ctl_decode(input word_t w);
        ctl_kind_e k;
        k = CTL_NONE;
        if (w[31:24] == 8'h01 || w[31:24] == 8'h02) k = CTL_ABORT;
        else if (w == 32'h0400_0000)                k = CTL_DIR_ABORT;
        else if (w[31:24] == 8'h04)                 k = CTL_DIR;
        return k;
    endfunction

endpackage

// File: rtl/gpa_len_lookup.sv
module gpa_len_lookup
    import gpa_pkg::*;
(
    input  opcode_t opcode,
    output cnt_t    extra
);
    always_comb extra = extra_words(opcode);
endmodule

// File: rtl/gpa_ctrl_unit.sv
module gpa_ctrl_unit
    import gpa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_valid,
    input  word_t            ctrl_word,
    output logic             abort,
    output logic [DIR_W-1:0] dma_dir
);
    ctl_kind_e kind;
    logic      dir_we;

    always_comb begin
        kind   = ctrl_valid ? ctl_decode(ctrl_word) : CTL_NONE;
        abort  = (kind == CTL_ABORT) || (kind == CTL_DIR_ABORT);
        dir_we = (kind == CTL_DIR) || (kind == CTL_DIR_ABORT);
    end

    always_ff @(posedge clk) begin
        if (rst)         dma_dir <= '0;
        else if (dir_we) dma_dir <= ctrl_word[DIR_W-1:0];
    end
endmodule

// File: rtl/gpa_collector.sv
module gpa_collector
    import gpa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      abort,
    input  opcode_t   opcode,
    input  cnt_t      extra,
    output logic      wr_en,
    output cnt_t      wr_idx,
    output logic      done,
    output pkt_info_t info,
    output logic      busy
);
    cnt_t      remain_q;
    cnt_t      idx_q;
    pkt_info_t pend_q;

    always_comb begin
        wr_en  = accept && !abort;
        wr_idx = busy ? idx_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            remain_q <= '0;
            idx_q    <= '0;
            pend_q   <= '0;
            done     <= 1'b0;
            info     <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy     <= 1'b0;
                remain_q <= '0;
            end else if (accept) begin
                if (!busy) begin
                    if (extra == '0) begin
                        done        <= 1'b1;
                        info.opcode <= opcode;
                        info.total  <= cnt_t'(1);
                    end else begin
                        busy          <= 1'b1;
                        remain_q      <= extra;
                        idx_q         <= cnt_t'(1);
                        pend_q.opcode <= opcode;
                        pend_q.total  <= cnt_t'(extra + cnt_t'(1));
                    end
                end else begin
                    remain_q <= cnt_t'(remain_q - cnt_t'(1));
                    idx_q    <= cnt_t'(idx_q + cnt_t'(1));
                    if (remain_q == cnt_t'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        info <= pend_q;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/gpa_pkt_store.sv
module gpa_pkt_store
    import gpa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  cnt_t                        wr_idx,
    input  word_t                       wr_data,
    output logic [MAX_WORDS*WORD_W-1:0] words
);
    for (genvar s = 0; s < MAX_WORDS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                words[s*WORD_W +: WORD_W] <= '0;
            else if (wr_en && wr_idx == cnt_t'(s))
                words[s*WORD_W +: WORD_W] <= wr_data;
        end
    end
endmodule

// File: rtl/gpu_packet_assembler.sv
module gpu_packet_assembler
    import gpa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [31:0]                 in_word,
    output logic                        in_ready,
    input  logic                        ctrl_valid,
    input  logic [31:0]                 ctrl_word,
    input  logic                        out_ready,
    output logic                        pkt_done,
    output logic [7:0]                  pkt_opcode,
    output logic [3:0]                  pkt_len,
    output logic [MAX_WORDS*WORD_W-1:0] pkt_words,
    output logic [1:0]                  dma_dir
);
    logic      abort_w;
    logic      accept_w;
    logic      wr_en_w;
    logic      busy_w;
    cnt_t      wr_idx_w;
    cnt_t      extra_w;
    pkt_info_t info_w;

    always_comb begin
        in_ready = !ctrl_valid && !(pkt_done && !out_ready);
        accept_w = in_valid && in_ready;
    end

    gpa_len_lookup u_len (
        .opcode (in_word[31:24]),
        .extra  (extra_w)
    );

    gpa_ctrl_unit u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_valid (ctrl_valid),
        .ctrl_word  (ctrl_word),
        .abort      (abort_w),
        .dma_dir    (dma_dir)
    );

    gpa_collector u_coll (
        .clk    (clk),
        .rst    (rst),
        .accept (accept_w),
        .abort  (abort_w),
        .opcode (in_word[31:24]),
        .extra  (extra_w),
        .wr_en  (wr_en_w),
        .wr_idx (wr_idx_w),
        .done   (pkt_done),
        .info   (info_w),
        .busy   (busy_w)
    );

    gpa_pkt_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_w),
        .wr_idx  (wr_idx_w),
        .wr_data (in_word),
        .words   (pkt_words)
    );

    always_comb begin
        pkt_opcode = info_w.opcode;
        pkt_len    = info_w.total;
    end
endmodule

// File: rtl/gpu_packet_assembler_chk.sv
module gpu_packet_assembler_chk
    import gpa_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        in_ready,
    input logic        ctrl_valid,
    input logic [31:0] ctrl_word,
    input logic        out_ready,
    input logic        pkt_done,
    input logic [7:0]  pkt_opcode,
    input logic [3:0]  pkt_len,
    input logic [1:0]  dma_dir,
    input logic        busy
);
    p_ctrl_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl_valid |-> !in_ready);

    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && !out_ready) |-> !in_ready);

    p_len_match_r2: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (pkt_len == 4'(extra_words(pkt_opcode) + 4'd1)));

    p_zero_len_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !busy && extra_words(in_word[31:24]) == '0)
        |=> (pkt_done && pkt_len == 4'd1 && pkt_opcode == $past(in_word[31:24])));

    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_valid && (ctrl_word[31:24] == 8'h01 || ctrl_word[31:24] == 8'h02)) |=> !busy);

    p_dir_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_valid |=> $stable(dma_dir));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!(in_valid && in_ready) && !ctrl_valid) |=> ($stable(busy) && !pkt_done));
endmodule

bind gpu_packet_assembler gpu_packet_assembler_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .in_ready   (in_ready),
    .ctrl_valid (ctrl_valid),
    .ctrl_word  (ctrl_word),
    .out_ready  (out_ready),
    .pkt_done   (pkt_done),
    .pkt_opcode (pkt_opcode),
    .pkt_len    (pkt_len),
    .dma_dir    (dma_dir),
    .busy       (busy_w)
);

// File: tb/gpu_packet_assembler_tb_top.sv
module gpu_packet_assembler_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [31:0]    in_word = '0;
    logic           in_ready;
    logic           ctrl_valid = 1'b0;
    logic [31:0]    ctrl_word = '0;
    logic           out_ready = 1'b1;
    logic           pkt_done;
    logic [7:0]     pkt_opcode;
    logic [3:0]     pkt_len;
    logic [NW*32-1:0] pkt_words;
    logic [1:0]     dma_dir;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpu_packet_assembler dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .ctrl_valid(ctrl_valid), .ctrl_word(ctrl_word),
        .out_ready(out_ready), .pkt_done(pkt_done), .pkt_opcode(pkt_opcode),
        .pkt_len(pkt_len), .pkt_words(pkt_words), .dma_dir(dma_dir)
    );

    function automatic int exp_extra(input logic [7:0] op);
        if (op >= 8'h20 && op <= 8'h3F) begin
            case (op[4:2])
                3'd0: return 3;  3'd1: return 6;  3'd2: return 4;  3'd3: return 8;
                3'd4: return 5;  3'd5: return 8;  3'd6: return 7;  default: return 11;
            endcase
        end
        if (op >= 8'h40 && op <= 8'h43) return 2;
        if (op >= 8'h48 && op <= 8'h53) return 3;
        if (op >= 8'h58 && op <= 8'h5F) return 4;
        if (op >= 8'h60 && op <= 8'h63) return 2;
        if (op >= 8'h64 && op <= 8'h67) return 3;
        if (op >= 8'h68 && op <= 8'h7F) return op[2] ? 2 : 1;
        if (op == 8'h02 || op == 8'hA0 || op == 8'hC0) return 2;
        if (op == 8'h80) return 3;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic ctrl(input logic [31:0] w);
        @(negedge clk);
        ctrl_valid = 1'b1;
        ctrl_word  = w;
        #1;
        chk("R8 in_ready during control", 32'(in_ready), 32'd0);
        @(posedge clk);
        #1;
        ctrl_valid = 1'b0;
    endtask

    function automatic logic [31:0] pword(input logic [7:0] op, input int k);
        return {8'hC5, op, 8'h00, 8'(k)} ^ 32'h0012_3400;
    endfunction

    // Full packet: header then parameters, checking timing and contents.
    task automatic run_packet(input logic [7:0] op, input string req);
        int n;
        logic [31:0] hdr;
        n   = exp_extra(op);
        hdr = {op, 24'h5A0F00} | 32'(op);
        push(hdr);
        if (n == 0) begin
            chk({req, " R3 zero-len done"}, 32'(pkt_done), 32'd1);
        end else begin
            chk({req, " R4 no early done"}, 32'(pkt_done), 32'd0);
            for (int k = 1; k <= n; k++) begin
                push(pword(op, k));
                if (k < n) chk({req, " R4 no early done"}, 32'(pkt_done), 32'd0);
            end
            chk({req, " R4 done after last"}, 32'(pkt_done), 32'd1);
            for (int k = 1; k <= n; k++)
                chk({req, " R4 param slot"}, pkt_words[32*k +: 32], pword(op, k));
        end
        chk({req, " R5 opcode"}, 32'(pkt_opcode), 32'(op));
        chk({req, " R2 length"}, 32'(pkt_len), 32'(n + 1));
        chk({req, " R4 header slot"}, pkt_words[31:0], hdr);
        @(posedge clk);
        #1;
        chk({req, " R5 single-cycle done"}, 32'(pkt_done), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 done at reset", 32'(pkt_done), 32'd0);
        chk("R1 ready at reset", 32'(in_ready), 32'd1);
        chk("R1 dir at reset", 32'(dma_dir), 32'd0);
        run_packet(8'hE1, "R1 first word is header");
    endtask

    task automatic t_table;
        logic [7:0] ops [26] = '{8'h00, 8'h02, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30,
                                 8'h34, 8'h38, 8'h3F, 8'h40, 8'h44, 8'h48, 8'h50,
                                 8'h56, 8'h5B, 8'h60, 8'h64, 8'h68, 8'h6C, 8'h77,
                                 8'h7A, 8'h80, 8'hA0, 8'hC0, 8'h81};
        foreach (ops[i]) run_packet(ops[i], "R2 table");
    endtask

    task automatic t_abort_reset_code;
        push(32'h2C00_0000);
        push(32'h1111_1111);
        push(32'h2222_2222);
        ctrl(32'h0100_0000);
        chk("R6 no done after abort", 32'(pkt_done), 32'd0);
        run_packet(8'h60, "R6 header after abort 01");
        push(32'h3800_0000);
        ctrl(32'h0200_0055);
        run_packet(8'h48, "R6 header after abort 02");
    endtask

    task automatic t_dir;
        ctrl(32'h0400_0002);
        chk("R7 dir set", 32'(dma_dir), 32'd2);
        push(32'h2000_0000);
        push(32'h0000_0001);
        ctrl(32'h0400_0001);
        chk("R7 dir updated", 32'(dma_dir), 32'd1);
        push(32'h0000_0002);
        chk("R7 partial kept, no early done", 32'(pkt_done), 32'd0);
        push(32'h0000_0003);
        chk("R7 partial kept, done", 32'(pkt_done), 32'd1);
        chk("R7 partial kept, len", 32'(pkt_len), 32'd4);
        push(32'h2400_0000);
        push(32'h0000_0009);
        ctrl(32'h0400_0000);
        chk("R7 exact word clears dir", 32'(dma_dir), 32'd0);
        run_packet(8'hE3, "R7 exact word aborts");
    endtask

    task automatic t_stall;
        out_ready = 1'b0;
        push(32'h6800_0000);
        push(32'h0007_0007);
        chk("R9 done present", 32'(pkt_done), 32'd1);
        chk("R9 not ready while downstream busy", 32'(in_ready), 32'd0);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 32'hE200_0000;
        @(posedge clk);
        #1;
        in_valid  = 1'b0;
        out_ready = 1'b1;
        chk("R10 blocked word not taken", 32'(pkt_done), 32'd0);
        chk("R9 ready again", 32'(in_ready), 32'd1);
        push(32'h6900_0000);
        push(32'h0001_0001);
        chk("R9 ready kept when downstream ready", 32'(in_ready), 32'd1);
        chk("R10 collection unaffected", 32'(pkt_opcode), 32'h69);
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_table();
        t_abort_reset_code();
        t_dir();
        t_stall();
        finish_run();
    end
endmodule